// File: doc/BRIEF.md
# Type-Length-Value Record Packer

This block packs type-length-value records into a fixed window of on-chip RAM. The window starts at `BASE_OFFSET` bytes into a save region of `REGION_BYTES` bytes and ends at the end of that region. The usable length is therefore `REGION_BYTES - BASE_OFFSET`. A requester issues a command that carries a type byte and a 16-bit payload length. The block writes a three-byte header and then copies the payload bytes from a valid/ready byte stream. It writes one byte per cycle through a byte-write port, and the RAM side can hold off that port with a busy input.

Before it writes anything, the block checks that the record fits. A record that would reach or pass the end of the window is refused whole, and no byte of it is written. A close command appends a single zero byte, the invalid type, which marks the end of the list. A reset moves the write pointer back to the start of the window.

The controller is a state machine with these states:
- `ST_IDLE`: waits for a command.
- `ST_TYPE`, `ST_LEN_LO`, `ST_LEN_HI`: write the three header bytes.
- `ST_PAYLOAD`: streams the payload.
- `ST_TERM`: writes the closing zero byte.
- `ST_FINISH`: a one-cycle completion state that pulses `done` and advances the pointer.

Its transitions are these:
- A refused command leaves the block in `ST_IDLE`.
- A record command moves `ST_IDLE` to `ST_TYPE`.
- A close command moves `ST_IDLE` to `ST_TERM`.
- The header states step in order whenever the write port is not busy.
- `ST_LEN_HI` goes to `ST_PAYLOAD`, or straight to `ST_FINISH` when the length is zero.
- `ST_PAYLOAD` goes to `ST_FINISH` after the last payload byte.
- `ST_TERM` goes to `ST_FINISH`.
- `ST_FINISH` returns to `ST_IDLE`.

Top module: `tlv_packer`

## Requirements
- R1: After reset the block is idle (`busy`=0), `done`=0, `err`=0, `mem_we`=0, and the write pointer equals `BASE_OFFSET`.
- R2: An accepted record writes its type byte at the write pointer P, then the length low byte at P+1, then the length high byte at P+2.
- R3: Payload byte k of a record is written at P+3+k, in arrival order, and each byte is consumed by exactly one `pl_valid`/`pl_ready` handshake.
- R4: A record command with P+3+len >= `REGION_BYTES` is refused. No byte is written, `err` becomes 1 and the pointer is unchanged. The sum is formed without wrap-around for any 16-bit length.
- R5: After an accepted record completes, the write pointer has advanced by len+3.
- R6: A close command writes one byte of value 0x00 at P and advances P by 1 when P < `REGION_BYTES`. Otherwise it writes nothing and sets `err`.
- R7: `done` is high for exactly one cycle, in the cycle after the last byte of an accepted record or close is written. A refused command produces no `done`.
- R8: `err` stays set until the next command is accepted in the idle state, and that command clears it.
- R9: A command presented while `busy`=1 is ignored and causes no write.
- R10: While `mem_busy`=1, `pl_ready` is 0, no payload is consumed, and the pending write's address stays unchanged until the port frees.
- R11: A record of length 0 writes only its three header bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; returns the pointer to the window start |
| cmd_go | input | 1 | Command strobe, taken only while idle |
| cmd_close | input | 1 | 1: append terminator, 0: write a record |
| cmd_type | input | 8 | Record type byte |
| cmd_len | input | 16 | Payload length in bytes |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte accepted this cycle when valid |
| mem_we | output | 1 | Byte write request |
| mem_addr | output | ADDR_W | Byte address inside the save region |
| mem_wdata | output | 8 | Byte to write |
| mem_busy | input | 1 | Write port busy; the request is held |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky out-of-space flag |

## Verification
The hardest case to reach is the exact boundary of the fit check: a record whose header plus payload would end exactly at the window end must be refused, while one byte less must be accepted. The stimulus gets there by walking the pointer forward with earlier records of chosen lengths until a 13-byte payload lands exactly on the limit. A 12-byte payload then fills to one byte short, and a close uses that last byte. A 0xFFFF length checks that the fit sum does not wrap. Busy cycles on the write port are interleaved with gaps in the payload stream, so that stalls hit header and payload bytes at different phases.

// File: rtl/tlvp_pkg.sv
package tlvp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_PAYLOAD,
        ST_TERM,
        ST_FINISH
    } tlvp_state_t;

    localparam int          TLVP_HDR_BYTES = 3;
    localparam logic [7:0]  TLVP_END_CODE  = 8'h00;
endpackage

// File: rtl/tlvp_fit_check.sv
module tlvp_fit_check #(
    parameter int PTR_W   = 7,
    parameter int BUF_END = 64
) (
    input  logic [PTR_W-1:0] wptr,
    input  logic [15:0]      len,
    input  logic             is_close,
    output logic             fits
);
    import tlvp_pkg::*;

    logic [17:0] need;

    always_comb begin
        need = 18'(wptr) + 18'(TLVP_HDR_BYTES) + 18'(len);
        if (is_close) begin
            fits = 18'(wptr) < 18'(BUF_END);
        end else begin
            fits = need < 18'(BUF_END);
        end
    end
endmodule

// File: rtl/tlvp_wptr.sv
module tlvp_wptr #(
    parameter int PTR_W    = 7,
    parameter int BUF_BASE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [16:0]      adv_amt,
    output logic [PTR_W-1:0] wptr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= PTR_W'(BUF_BASE);
        end else if (adv) begin
            wptr <= wptr + PTR_W'(adv_amt);
        end
    end
endmodule

// File: rtl/tlv_packer.sv
module tlv_packer #(
    parameter int REGION_BYTES = 64,
    parameter int BASE_OFFSET  = 32,
    parameter int ADDR_W       = $clog2(REGION_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_close,
    input  logic [7:0]        cmd_type,
    input  logic [15:0]       cmd_len,
    input  logic              pl_valid,
    input  logic [7:0]        pl_data,
    output logic              pl_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_busy,
    output logic              busy,
    output logic              done,
    output logic              err
);
    import tlvp_pkg::*;

    localparam int PTR_W = ADDR_W + 1;

    tlvp_state_t      state;
    logic [17:0]      ofs;
    logic [7:0]       typ_q;
    logic [15:0]      len_q;
    logic             close_q;
    logic             fits;
    logic             adv;
    logic [16:0]      adv_amt;
    logic [PTR_W-1:0] wptr;
    logic             take;
    logic             last_pl;

    tlvp_fit_check #(.PTR_W(PTR_W), .BUF_END(REGION_BYTES)) u_fit (
        .wptr     (wptr),
        .len      (cmd_len),
        .is_close (cmd_close),
        .fits     (fits)
    );

    tlvp_wptr #(.PTR_W(PTR_W), .BUF_BASE(BASE_OFFSET)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .adv_amt (adv_amt),
        .wptr    (wptr)
    );

    assign take    = (state == ST_IDLE) && cmd_go;
    assign last_pl = (ofs == (18'(len_q) + 18'd2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ofs     <= '0;
            typ_q   <= '0;
            len_q   <= '0;
            close_q <= 1'b0;
            err     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        err     <= !fits;
                        typ_q   <= cmd_type;
                        len_q   <= cmd_len;
                        close_q <= cmd_close;
                        ofs     <= '0;
                        if (fits) begin
                            state <= cmd_close ? ST_TERM : ST_TYPE;
                        end
                    end
                end
                ST_TYPE: begin
                    if (!mem_busy) begin
                        state <= ST_LEN_LO;
                        ofs   <= 18'd1;
                    end
                end
                ST_LEN_LO: begin
                    if (!mem_busy) begin
                        state <= ST_LEN_HI;
                        ofs   <= 18'd2;
                    end
                end
                ST_LEN_HI: begin
                    if (!mem_busy) begin
                        ofs   <= 18'd3;
                        state <= (len_q == 16'd0) ? ST_FINISH : ST_PAYLOAD;
                    end
                end
                ST_PAYLOAD: begin
                    if (pl_valid && !mem_busy) begin
                        ofs <= ofs + 18'd1;
                        if (last_pl) begin
                            state <= ST_FINISH;
                        end
                    end
                end
                ST_TERM: begin
                    if (!mem_busy) begin
                        state <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = 8'h00;
        pl_ready  = 1'b0;
        done      = 1'b0;
        adv       = 1'b0;
        adv_amt   = close_q ? 17'd1 : (17'(len_q) + 17'(TLVP_HDR_BYTES));
        busy      = (state != ST_IDLE);
        mem_addr  = ADDR_W'(wptr + PTR_W'(ofs));
        unique case (state)
            ST_IDLE: begin
            end
            ST_TYPE: begin
                mem_we    = 1'b1;
                mem_wdata = typ_q;
            end
            ST_LEN_LO: begin
                mem_we    = 1'b1;
                mem_wdata = len_q[7:0];
            end
            ST_LEN_HI: begin
                mem_we    = 1'b1;
                mem_wdata = len_q[15:8];
            end
            ST_PAYLOAD: begin
                mem_we    = pl_valid;
                mem_wdata = pl_data;
                pl_ready  = !mem_busy;
            end
            ST_TERM: begin
                mem_we    = 1'b1;
                mem_wdata = TLVP_END_CODE;
            end
            ST_FINISH: begin
                done = 1'b1;
                adv  = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/tlvp_checker.sv
module tlvp_checker #(
    parameter int BUF_BASE = 32,
    parameter int BUF_END  = 64,
    parameter int ADDR_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_go,
    input logic              busy,
    input logic              fit_ok,
    input logic              mem_we,
    input logic              mem_busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pl_ready,
    input logic              done,
    input logic              err
);
    assert_busy_blocks_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |-> !pl_ready);

    assert_stall_holds_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_busy) |=> $stable(mem_addr));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(cmd_go && !busy)) |=> err);

    assert_refuse_sets_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !busy && !fit_ok) |=> (err && !busy));

    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    assert_write_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((int'(mem_addr) >= BUF_BASE) && (int'(mem_addr) < BUF_END)));
endmodule

bind tlv_packer tlvp_checker #(
    .BUF_BASE (BASE_OFFSET),
    .BUF_END  (REGION_BYTES),
    .ADDR_W   (ADDR_W)
) u_tlvp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .busy     (busy),
    .fit_ok   (fits),
    .mem_we   (mem_we),
    .mem_busy (mem_busy),
    .mem_addr (mem_addr),
    .pl_ready (pl_ready),
    .done     (done),
    .err      (err)
);

// File: tb/tb_tlv_packer.sv
`timescale 1ns/1ps
module tb_tlv_packer;
    localparam int REGION = 64;
    localparam int BASE   = 32;
    localparam int AW     = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_go = 1'b0;
    logic          cmd_close = 1'b0;
    logic [7:0]    cmd_type = '0;
    logic [15:0]   cmd_len = '0;
    logic          pl_valid = 1'b0;
    logic [7:0]    pl_data = '0;
    logic          pl_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_busy = 1'b0;
    logic          busy;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int stall_hits = 0;
    int exp_wp = BASE;
    bit stall_en = 1'b0;
    bit finished = 1'b0;
    logic [15:0] expq[$];

    always #2.5 clk = ~clk;

    tlv_packer #(.REGION_BYTES(REGION), .BASE_OFFSET(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_close(cmd_close),
        .cmd_type(cmd_type), .cmd_len(cmd_len), .pl_valid(pl_valid),
        .pl_data(pl_data), .pl_ready(pl_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_busy(mem_busy),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // stall generator for the write port
    initial begin
        int scyc = 0;
        forever begin
            @(posedge clk);
            #1;
            scyc++;
            mem_busy = stall_en && (scyc % 3 == 0);
        end
    end

    // monitor: pops expected writes and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (mem_busy && mem_we) stall_hits++;
            if (mem_busy && pl_ready) check(1'b0, "R10 ready during busy", 1, 0);
            if (mem_we && !mem_busy) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 R4 unexpected write", {mem_addr, mem_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    check({2'b00, mem_addr, mem_wdata} == e, "R2 R3 R6 write addr/data",
                          {2'b00, mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    function automatic logic [15:0] item(input int a, input logic [7:0] d);
        return {8'(a), d};
    endfunction

    task automatic run_cmd(input bit close, input logic [7:0] typ, input logic [15:0] len,
                           input bit gaps, input bit poke);
        int  d0;
        bit  fits;
        d0 = done_cnt;
        if (close) fits = exp_wp < REGION;
        else       fits = (exp_wp + 3 + int'(len)) < REGION;
        if (fits) begin
            if (close) begin
                expq.push_back(item(exp_wp, 8'h00));
            end else begin
                expq.push_back(item(exp_wp, typ));
                expq.push_back(item(exp_wp + 1, len[7:0]));
                expq.push_back(item(exp_wp + 2, len[15:8]));
                for (int k = 0; k < int'(len); k++)
                    expq.push_back(item(exp_wp + 3 + k, typ ^ 8'(k * 13 + 1)));
            end
        end
        @(posedge clk); #1;
        cmd_go = 1'b1; cmd_close = close; cmd_type = typ; cmd_len = len;
        @(posedge clk); #1;
        cmd_go = 1'b0;
        if (fits && !close) begin
            for (int k = 0; k < int'(len); k++) begin
                if (gaps && (k % 2 == 1)) begin
                    @(posedge clk); #1;
                end
                if (poke && k == 1) begin
                    cmd_go = 1'b1; cmd_close = 1'b1;   // R9: must be ignored
                end
                pl_valid = 1'b1;
                pl_data  = typ ^ 8'(k * 13 + 1);
                forever begin
                    @(negedge clk);
                    if (pl_ready) break;
                end
                @(posedge clk); #1;
                pl_valid = 1'b0;
                cmd_go   = 1'b0;
            end
        end
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        check((done_cnt - d0) == (fits ? 1 : 0), "R7 done pulse count", done_cnt - d0, fits ? 1 : 0);
        check(err == !fits, "R4 R6 R8 err flag", err, !fits);
        check(expq.size() == 0, "R2 R3 R11 missing writes", expq.size(), 0);
        if (fits) exp_wp += close ? 1 : int'(len) + 3;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(done == 0, "R1 done after reset", done, 0);
        check(err == 0, "R1 err after reset", err, 0);
        check(mem_we == 0, "R1 mem_we after reset", mem_we, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        run_cmd(1'b0, 8'h11, 16'd4, 1'b0, 1'b1);   // R2 R3 R9, P=32
        run_cmd(1'b0, 8'h22, 16'd0, 1'b0, 1'b0);   // R11, P=39
        stall_en = 1'b1;
        run_cmd(1'b0, 8'h33, 16'd3, 1'b1, 1'b0);   // R10 R5, P=42
        stall_en = 1'b0;
        check(stall_hits > 0, "R10 stall exercised", stall_hits, 1);
        run_cmd(1'b0, 8'h44, 16'hFFFF, 1'b0, 1'b0); // R4 no wrap, P=48
        run_cmd(1'b0, 8'h55, 16'd13, 1'b0, 1'b0);   // R4 exact end refused
        run_cmd(1'b0, 8'h66, 16'd12, 1'b0, 1'b0);   // R8 clears, R5 P=48->63
        run_cmd(1'b1, 8'h00, 16'd0, 1'b0, 1'b0);    // R6 close at 63
        run_cmd(1'b1, 8'h00, 16'd0, 1'b0, 1'b0);    // R6 close refused at 64

        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(err == 0, "R1 err cleared by reset", err, 0);
        exp_wp = BASE;
        run_cmd(1'b0, 8'h5A, 16'd0, 1'b0, 1'b0);    // R1 pointer back at base

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule